// File: doc/BRIEF.md
# DMA Segment Length Planner

This unit decides how a long transfer of 64-bit words is cut into segments for a DMA-driven SPI engine. Each time software or a sequencer asks, it takes the number of words still to move and the depth of the data FIFO. It returns the length of the next segment, the DMA burst length to use inside that segment, how many such bursts the segment holds, and the word count left over once the segment is done. The caller loops, feeding the leftover count back in, until nothing remains.

A short remainder that fits in the FIFO is sent as one segment and one burst. A very long remainder is capped at the largest segment that a 16-bit burst counter can describe at the default burst length of 8. Between those two cases the unit searches for the largest burst length from 8 down to 2 that divides the remainder exactly, testing one candidate per clock. If no candidate divides it, the segment is trimmed to a multiple of 8, and the trim is chosen so that a single word is never left on its own at the end. A remainder below two words cannot start a DMA burst and is flagged as an error.

A request is accepted on a `start_i` pulse while the unit is idle. `done_o` pulses once when the results are valid, and the results hold until the next accepted request.

Top module: `dma_seg_planner`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are 0 and `seg_len_o`, `burst_len_o`, `burst_cnt_o` and `remain_next_o` are all 0.
- R2: A remaining count below 2 gives `err_o`=1 with segment, burst length and burst count all 0, and `remain_next_o` equal to the count.
- R3: A count from 2 up to `fifo_depth_i` gives a segment equal to the count, a burst length equal to the count and a burst count of 1.
- R4: A count of exactly MAX+1 gives a segment of MAX-8 with burst length 8, where MAX = 8 x 65535 = 524280 words at default parameters.
- R5: Any other count of MAX or more gives a segment of MAX with burst length 8.
- R6: Otherwise the burst length is the largest value k from 8 down to 2 that divides the count exactly, and the segment is the whole count.
- R7: If no k from 8 to 2 divides the count, the segment is the count minus (count mod 8) with burst length 8; when that residue is 1, a further 8 is taken off the segment.
- R8: The burst count equals the segment divided by the burst length rounded up, and `remain_next_o` equals the count minus the segment.
- R9: `done_o` is a single-cycle pulse arriving L clock edges after the edge that accepts `start_i`: L=1 for R2 to R5, L=2+(8-k) for a divisor k, and L=8 when no divisor is found; `busy_o` is 1 from the accepting edge until that pulse.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: it produces no extra `done_o` and does not change the results of the request in flight.
- R11: All result outputs hold their values from one `done_o` pulse until the next accepted request completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted while idle |
| remain_i | input | 24 | Words still to move, sampled at acceptance |
| fifo_depth_i | input | 8 | FIFO depth in words, sampled at acceptance |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| err_o | output | 1 | Count too short for a DMA burst |
| seg_len_o | output | 24 | Words in the next segment |
| burst_len_o | output | 8 | Words per DMA burst in the segment |
| burst_cnt_o | output | 24 | DMA bursts in the segment |
| remain_next_o | output | 24 | Words left after the segment |

## Verification
A candidate counter that skips or repeats a step shows up at the ports as a wrong burst length on the next `done_o` and, because the search is one candidate per cycle, also as a pulse that arrives earlier or later than the latency in R9; the bench measures both for every request. A stale operand register or a result register that loads outside its completion cycle breaks the hold rule of R11 within a few cycles of a pulse, and a busy flag that clears early lets the mid-search start of R10 replace the result. Burst length times burst count must always give the segment, so a wrong quotient is exposed on the same pulse.

// File: rtl/dma_seg_pkg.sv
// Shared types for the DMA segment planner.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_seg_pkg;

    // Controller states: idle, one classification cycle, divisor search.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CLASSIFY = 2'd1,
        ST_SEARCH   = 2'd2
    } seg_state_e;

    // Which rule produced the result.
    typedef enum logic [2:0] {
        K_ERR   = 3'd0,
        K_SMALL = 3'd1,
        K_TAIL  = 3'd2,
        K_CAP   = 3'd3,
        K_DIV   = 3'd4,
        K_TRIM  = 3'd5
    } seg_kind_e;

endpackage

// File: rtl/dma_seg_residue.sv
// Residue and quotient bank for the divisor search.
// Builds one constant-divisor unit per candidate burst length
// (MIN_BURST..DEF_BURST) and selects the one named by cand_i.
// Assumes: cand_i always lies within MIN_BURST..DEF_BURST when used.
module dma_seg_residue #(
    parameter int CNT_W     = 24,
    parameter int MIN_BURST = 2,
    parameter int DEF_BURST = 8,
    parameter int CAND_W    = $clog2(DEF_BURST + 1)
) (
    input  logic [CNT_W-1:0]  val_i,
    input  logic [CAND_W-1:0] cand_i,
    output logic              zero_o,
    output logic [CNT_W-1:0]  quot_o
);
    localparam int NCAND = DEF_BURST - MIN_BURST + 1;

    logic             zero_a [NCAND];
    logic [CNT_W-1:0] quot_a [NCAND];

    // One constant-modulus unit per candidate.
    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        localparam logic [CNT_W-1:0] DIV_C = CNT_W'(MIN_BURST + g);
        assign zero_a[g] = ((val_i % DIV_C) == '0);
        assign quot_a[g] = val_i / DIV_C;
    end

    // Select the unit for the current candidate.
    always_comb begin
        zero_o = 1'b0;
        quot_o = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (cand_i == CAND_W'(MIN_BURST + k)) begin
                zero_o = zero_a[k];
                quot_o = quot_a[k];
            end
        end
    end

endmodule

// File: rtl/dma_seg_ctrl.sv
// Sequencer for the DMA segment planner.
// Accepts a request while idle, spends one cycle on the direct rules,
// then walks the candidate burst length down one step per cycle until a
// divisor is found or the smallest candidate fails.
// Assumes: classification inputs are stable while busy.
module dma_seg_ctrl
    import dma_seg_pkg::*;
#(
    parameter int MIN_BURST = 2,
    parameter int DEF_BURST = 8,
    parameter int CAND_W    = $clog2(DEF_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cls_err_i,
    input  logic              cls_small_i,
    input  logic              cls_tail_i,
    input  logic              cls_cap_i,
    input  logic              res_zero_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic [CAND_W-1:0] cand_o,
    output logic              fin_o,
    output seg_kind_e         kind_o
);
    localparam logic [CAND_W-1:0] CAND_TOP = CAND_W'(DEF_BURST);
    localparam logic [CAND_W-1:0] CAND_BOT = CAND_W'(MIN_BURST);

    seg_state_e        state_q;
    logic [CAND_W-1:0] cand_q;

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign busy_o   = (state_q != ST_IDLE);
    assign cand_o   = cand_q;

    // Decide whether this cycle completes the request, and by which rule.
    always_comb begin
        fin_o  = 1'b0;
        kind_o = K_ERR;
        case (state_q)
            ST_CLASSIFY: begin
                if (cls_err_i)        begin fin_o = 1'b1; kind_o = K_ERR;   end
                else if (cls_small_i) begin fin_o = 1'b1; kind_o = K_SMALL; end
                else if (cls_tail_i)  begin fin_o = 1'b1; kind_o = K_TAIL;  end
                else if (cls_cap_i)   begin fin_o = 1'b1; kind_o = K_CAP;   end
            end
            ST_SEARCH: begin
                if (res_zero_i)             begin fin_o = 1'b1; kind_o = K_DIV;  end
                else if (cand_q == CAND_BOT) begin fin_o = 1'b1; kind_o = K_TRIM; end
            end
            default: ;
        endcase
    end

    // State and candidate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cand_q  <= CAND_TOP;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_CLASSIFY;
                ST_CLASSIFY: begin
                    cand_q  <= CAND_TOP;
                    state_q <= fin_o ? ST_IDLE : ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (fin_o) state_q <= ST_IDLE;
                    else       cand_q  <= cand_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    cand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> (cand_q >= CAND_BOT && cand_q <= CAND_TOP));

    // R9
    cand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && !res_zero_i && cand_q != CAND_BOT)
            |=> (cand_q == $past(cand_q) - 1'b1));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/dma_seg_planner.sv
// DMA segment planner top.
// Latches the remaining word count and FIFO depth on an accepted start,
// classifies the count, runs the divisor search through the sequencer and
// residue bank, and registers segment length, burst length, burst count
// and leftover count when the sequencer signals completion.
// Assumes: fifo_depth_i >= MIN_BURST; CNT_W > FIFO_W; CNT_W holds MAX+1.
module dma_seg_planner
    import dma_seg_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int FIFO_W    = 8,
    parameter int BCNT_W    = 16,
    parameter int MIN_BURST = 2,
    parameter int DEF_BURST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic [FIFO_W-1:0] fifo_depth_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  seg_len_o,
    output logic [FIFO_W-1:0] burst_len_o,
    output logic [CNT_W-1:0]  burst_cnt_o,
    output logic [CNT_W-1:0]  remain_next_o
);
    localparam int CAND_W = $clog2(DEF_BURST + 1);
    localparam logic [CNT_W-1:0]  MAX_SEG_C = CNT_W'(DEF_BURST * (2**BCNT_W - 1));
    localparam logic [CNT_W-1:0]  DEF_C     = CNT_W'(DEF_BURST);
    localparam logic [CNT_W-1:0]  MIN_C     = CNT_W'(MIN_BURST);
    localparam logic [FIFO_W-1:0] DEF_F     = FIFO_W'(DEF_BURST);
    localparam logic [FIFO_W-1:0] MIN_F     = FIFO_W'(MIN_BURST);

    logic [CNT_W-1:0]  rem_q;
    logic [FIFO_W-1:0] fifo_q;
    logic              accept;
    logic              fin;
    seg_kind_e         kind;
    logic [CAND_W-1:0] cand;
    logic              res_zero;
    logic [CNT_W-1:0]  res_quot;
    logic [CNT_W-1:0]  fifo_ext;
    logic              cls_err, cls_small, cls_tail, cls_cap;
    logic [CNT_W-1:0]  tail_res;
    logic [CNT_W-1:0]  seg_trim;

    // Operand capture on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            fifo_q <= '0;
        end else if (accept) begin
            rem_q  <= remain_i;
            fifo_q <= fifo_depth_i;
        end
    end

    // Direct-rule classification of the captured count.
    always_comb begin
        fifo_ext  = {{(CNT_W-FIFO_W){1'b0}}, fifo_q};
        cls_err   = (rem_q < MIN_C);
        cls_small = (rem_q <= fifo_ext);
        cls_tail  = (rem_q == MAX_SEG_C + 1'b1);
        cls_cap   = (rem_q >= MAX_SEG_C);
    end

    // Trimmed segment when no candidate divides the count.
    always_comb begin
        tail_res = rem_q % DEF_C;
        seg_trim = rem_q - tail_res;
        if (tail_res == CNT_W'(1)) seg_trim = seg_trim - DEF_C;
    end

    dma_seg_ctrl #(
        .MIN_BURST (MIN_BURST),
        .DEF_BURST (DEF_BURST),
        .CAND_W    (CAND_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cls_err_i   (cls_err),
        .cls_small_i (cls_small),
        .cls_tail_i  (cls_tail),
        .cls_cap_i   (cls_cap),
        .res_zero_i  (res_zero),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .cand_o      (cand),
        .fin_o       (fin),
        .kind_o      (kind)
    );

    dma_seg_residue #(
        .CNT_W     (CNT_W),
        .MIN_BURST (MIN_BURST),
        .DEF_BURST (DEF_BURST),
        .CAND_W    (CAND_W)
    ) u_residue (
        .val_i  (rem_q),
        .cand_i (cand),
        .zero_o (res_zero),
        .quot_o (res_quot)
    );

    // Result registers, loaded only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o        <= 1'b0;
            err_o         <= 1'b0;
            seg_len_o     <= '0;
            burst_len_o   <= '0;
            burst_cnt_o   <= '0;
            remain_next_o <= '0;
        end else begin
            done_o <= fin;
            if (fin) begin
                err_o <= (kind == K_ERR);
                case (kind)
                    K_ERR: begin
                        seg_len_o     <= '0;
                        burst_len_o   <= '0;
                        burst_cnt_o   <= '0;
                        remain_next_o <= rem_q;
                    end
                    K_SMALL: begin
                        seg_len_o     <= rem_q;
                        burst_len_o   <= rem_q[FIFO_W-1:0];
                        burst_cnt_o   <= CNT_W'(1);
                        remain_next_o <= '0;
                    end
                    K_TAIL: begin
                        seg_len_o     <= MAX_SEG_C - DEF_C;
                        burst_len_o   <= DEF_F;
                        burst_cnt_o   <= (MAX_SEG_C - DEF_C) / DEF_C;
                        remain_next_o <= rem_q - (MAX_SEG_C - DEF_C);
                    end
                    K_CAP: begin
                        seg_len_o     <= MAX_SEG_C;
                        burst_len_o   <= DEF_F;
                        burst_cnt_o   <= MAX_SEG_C / DEF_C;
                        remain_next_o <= rem_q - MAX_SEG_C;
                    end
                    K_DIV: begin
                        seg_len_o     <= rem_q;
                        burst_len_o   <= FIFO_W'(cand);
                        burst_cnt_o   <= res_quot;
                        remain_next_o <= '0;
                    end
                    default: begin
                        seg_len_o     <= seg_trim;
                        burst_len_o   <= DEF_F;
                        burst_cnt_o   <= seg_trim / DEF_C;
                        remain_next_o <= rem_q - seg_trim;
                    end
                endcase
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    burst_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |->
            (({{(CNT_W-FIFO_W){1'b0}}, burst_len_o} * burst_cnt_o) == seg_len_o));

    // R6
    burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o && seg_len_o > {{(CNT_W-FIFO_W){1'b0}}, fifo_q})
            |-> (burst_len_o >= MIN_F && burst_len_o <= DEF_F));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o))
            |-> ($stable(seg_len_o) && $stable(burst_len_o) && $stable(burst_cnt_o)));

    // R2
    err_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (seg_len_o == '0 && remain_next_o < MIN_C));

endmodule

// File: tb/dma_seg_planner_tb.sv
// Scoreboard bench for dma_seg_planner: a driver pushes expected results
// computed from the requirements; a monitor pops them on each done pulse.
module dma_seg_planner_tb;
    localparam int CNT_W  = 24;
    localparam int FIFO_W = 8;
    localparam int MAXS   = 8 * 65535;

    typedef struct {
        int unsigned seg, bl, cnt, nxt;
        bit          err;
        int          lat;
        int          t0;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  remain_i = '0;
    logic [FIFO_W-1:0] fifo_depth_i = '0;
    logic              busy_o, done_o, err_o;
    logic [CNT_W-1:0]  seg_len_o, burst_cnt_o, remain_next_o;
    logic [FIFO_W-1:0] burst_len_o;

    exp_t q[$];
    exp_t last;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   prev_done = 1'b0;
    bit   ended = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dma_seg_planner u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .remain_i (remain_i),
        .fifo_depth_i (fifo_depth_i), .busy_o (busy_o), .done_o (done_o),
        .err_o (err_o), .seg_len_o (seg_len_o), .burst_len_o (burst_len_o),
        .burst_cnt_o (burst_cnt_o), .remain_next_o (remain_next_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Independent model of the segment rules (R2..R9).
    function automatic exp_t model(input int unsigned rem, input int unsigned fifo);
        exp_t e;
        int unsigned r;
        e.err = 0; e.lat = 1;
        if (rem < 2) begin
            e.err = 1; e.seg = 0; e.bl = 0; e.cnt = 0; e.nxt = rem;
            return e;
        end
        if (rem <= fifo)            begin e.seg = rem; e.bl = rem; end
        else if (rem == MAXS + 1)   begin e.seg = MAXS - 8; e.bl = 8; end
        else if (rem >= MAXS)       begin e.seg = MAXS; e.bl = 8; end
        else begin
            e.bl = 0;
            for (int k = 8; k >= 2; k--) begin
                if (e.bl == 0 && (rem % k) == 0) begin
                    e.bl = k; e.seg = rem; e.lat = 2 + (8 - k);
                end
            end
            if (e.bl == 0) begin
                r = rem % 8;
                e.seg = rem - r - ((r == 1) ? 8 : 0);
                e.bl = 8; e.lat = 8;
            end
        end
        e.cnt = (e.seg + e.bl - 1) / e.bl;
        e.nxt = rem - e.seg;
        return e;
    endfunction

    // Monitor: compare each done pulse with the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done) chk(0, "R9 done wider than one cycle", 1, 0);
            if (done_o) begin
                if (q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(err_o == e.err,         "R2 err_o", err_o, e.err);
                    chk(seg_len_o == e.seg,     "R3-R7 seg_len", seg_len_o, e.seg);
                    chk(burst_len_o == e.bl,    "R6 burst_len", burst_len_o, e.bl);
                    chk(burst_cnt_o == e.cnt,   "R8 burst_cnt", burst_cnt_o, e.cnt);
                    chk(remain_next_o == e.nxt, "R8 remain_next", remain_next_o, e.nxt);
                    chk((cyc - e.t0 - 1) == e.lat, "R9 latency", cyc - e.t0 - 1, e.lat);
                end
            end
            prev_done = done_o;
        end
    end

    // Driver: one request, optional ignored start mid-flight (R10).
    task automatic plan(input int unsigned rem, input int unsigned fifo, input bit poke);
        exp_t e;
        @(negedge clk);
        e = model(rem, fifo);
        e.t0 = cyc;
        remain_i = CNT_W'(rem);
        fifo_depth_i = FIFO_W'(fifo);
        start_i = 1'b1;
        q.push_back(e);
        last = e;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
        if (poke) begin
            @(negedge clk);
            remain_i = CNT_W'(24);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(seg_len_o == last.seg,     "R11 seg hold", seg_len_o, last.seg);
        chk(burst_len_o == last.bl,    "R11 burst_len hold", burst_len_o, last.bl);
        chk(remain_next_o == last.nxt, "R11 remain hold", remain_next_o, last.nxt);
        chk(busy_o == 1'b0,            "R10 idle after done", busy_o, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(done_o == 0 && busy_o == 0 && err_o == 0, "R1 flags", {done_o, busy_o, err_o}, 0);
        chk(seg_len_o == 0 && burst_len_o == 0 && burst_cnt_o == 0 && remain_next_o == 0,
            "R1 results", seg_len_o, 0);
        plan(1, 16, 0);        // R2
        plan(0, 16, 0);        // R2
        plan(2, 16, 0);        // R3
        plan(16, 16, 0);       // R3
        plan(24, 16, 0);       // R6 k=8
        plan(21, 16, 0);       // R6 k=7
        plan(18, 16, 0);       // R6 k=6
        plan(25, 16, 0);       // R6 k=5
        plan(20, 16, 0);       // R6 k=5 before 4
        plan(27, 16, 0);       // R6 k=3
        plan(22, 16, 0);       // R6 k=2
        plan(17, 16, 0);       // R7 residue 1
        plan(23, 16, 0);       // R7 residue 7
        plan(11, 4, 0);        // R7 small FIFO
        plan(5, 4, 0);         // R6 k=5
        plan(MAXS, 16, 0);     // R5
        plan(MAXS + 1, 16, 0); // R4
        plan(1000000, 16, 0);  // R5
        plan(262142, 16, 0);   // R8 large count
        plan(22, 16, 1);       // R10 start while busy
        repeat (10) @(negedge clk);
        finish_run();
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000 && !ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

endmodule